// File: doc/BRIEF.md
# Barrel Thread Fetch Scheduler

This block picks which hardware thread fetches next in a fine-grained multithreaded front end. It keeps a program counter and a state for every thread context. The thread IDs that may fetch are held in an ordered pool, and the head of that pool is offered on a valid/ready fetch port. Once a thread's fetch is accepted, the thread leaves the pool and is held out of it until the rest of the machine reports that its instruction has resolved. Because of this rule, no thread ever has two instructions in the pipeline at once. The rest of the machine therefore needs no branch prediction and no dependency checks within a thread.

The resolve port carries a thread ID and the PC that thread should fetch next. It is always accepted and has no ready signal. A normal resolve sends the thread to the tail of the pool. A resolve with the park flag set stores the PC but leaves the thread waiting, which is how a long-latency operation is modelled. A later resolve without the flag releases the thread. When the pool is empty, the port shows a bubble. With at least as many enabled threads as pipeline stages, every thread fetches once per round of the pool. Each thread's boot PC is `BOOT_BASE + tid*BOOT_STRIDE`, and a mask parameter chooses which threads take part.

Top module: `bts_barrel_fetch`

## Requirements
- R1: After reset, the enabled threads are offered in ascending ID order, each with its boot PC (base plus ID times stride). A thread whose bit in `THREAD_EN` is 0 is never offered.
- R2: Once a thread's fetch is accepted (`fetch_valid && fetch_ready` on a clock edge), that thread is not offered again until a resolve for it has been accepted.
- R3: Two fetches accepted on consecutive clock edges always carry different thread IDs.
- R4: A resolve with `done_park`=0 for an in-flight thread stores `done_pc` as that thread's PC. It places the thread at the tail of the pool, behind every thread already queued, and the thread can be offered from the next cycle.
- R5: When every issued thread resolves one cycle after its fetch, the pool rotates in a fixed order. Each of the K enabled threads is fetched once every K accepted fetches, and a push and a pop in the same cycle both take effect.
- R6: When no thread is in the pool, `fetch_valid` is 0.
- R7: While `fetch_valid` is 1 and `fetch_ready` is 0, the offered `fetch_tid` and `fetch_pc` stay unchanged and the pool is not popped.
- R8: A resolve with `done_park`=1 stores `done_pc` but keeps the thread out of the pool. A later parked resolve only updates the PC. A resolve with `done_park`=0 returns the thread to the pool with the last PC it was given.
- R9: A resolve for a thread that is currently in the pool has no effect: its PC is unchanged and it is not queued a second time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_valid | output | 1 | A thread is offered for fetch |
| fetch_ready | input | 1 | Downstream accepts the offered fetch |
| fetch_tid | output | TID_W | Offered thread ID |
| fetch_pc | output | PC_W | PC of the offered thread |
| done_valid | input | 1 | Resolve event, always accepted |
| done_tid | input | TID_W | Thread whose instruction resolved |
| done_pc | input | PC_W | Next PC for that thread |
| done_park | input | 1 | 1 keeps the thread waiting (long-latency operation) |

## Verification
The bench targets these corner cases:
- **Drained pool.** It runs the pool dry and checks for bubbles. A scheduler that re-offered a busy thread would show a valid fetch there instead.
- **Back-pressure.** It holds the fetch port in back-pressure while sending a stray resolve for the thread at the head. A design that popped while stalled, or that accepted resolves for queued threads, would show a changed PC or the same ID twice.
- **Parking.** It parks a thread twice before releasing it, which catches a design that requeues on a parked resolve or keeps a stale PC.
- **Rotation.** It checks a long rotation where every cycle both pushes and pops. A pointer or count error there shows up as a wrong order or a lost thread.

// File: rtl/bts_pkg.sv
package bts_pkg;

  // Per-thread scheduling state
  typedef enum logic [1:0] {
    TH_QUEUED   = 2'd0,  // in the available pool
    TH_INFLIGHT = 2'd1,  // fetched, waiting for its resolve
    TH_PARKED   = 2'd2   // waiting on a long-latency operation
  } th_state_e;

endpackage

// File: rtl/bts_tid_fifo.sv
module bts_tid_fifo #(
  parameter int            N_THREADS = 8,
  parameter int            TID_W     = 3,
  parameter logic [N_THREADS-1:0] INIT_MASK = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [TID_W-1:0] push_tid,
  input  logic             pop,
  output logic             not_empty,
  output logic [TID_W-1:0] head_tid
);

  localparam int CNT_W = $clog2(N_THREADS + 1);

  function automatic logic [N_THREADS*TID_W-1:0] boot_order(input logic [N_THREADS-1:0] m);
    logic [N_THREADS*TID_W-1:0] r;
    int k;
    r = '0;
    k = 0;
    for (int i = 0; i < N_THREADS; i++) begin
      if (m[i]) begin
        r[k*TID_W +: TID_W] = TID_W'(i);
        k++;
      end
    end
    return r;
  endfunction

  function automatic int boot_count(input logic [N_THREADS-1:0] m);
    int c;
    c = 0;
    for (int i = 0; i < N_THREADS; i++) c += int'(m[i]);
    return c;
  endfunction

  localparam logic [N_THREADS*TID_W-1:0] INIT_SLOTS = boot_order(INIT_MASK);
  localparam int INIT_CNT = boot_count(INIT_MASK);
  localparam logic [TID_W-1:0] INIT_WR = TID_W'(INIT_CNT % N_THREADS);

  logic [N_THREADS-1:0][TID_W-1:0] slot_q;
  logic [TID_W-1:0] rd_q, wr_q;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [TID_W-1:0] step(input logic [TID_W-1:0] p);
    return (p == TID_W'(N_THREADS - 1)) ? '0 : p + 1'b1;
  endfunction

  assign not_empty = (cnt_q != '0);
  assign head_tid  = slot_q[rd_q];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= INIT_SLOTS;
      rd_q   <= '0;
      wr_q   <= INIT_WR;
      cnt_q  <= CNT_W'(INIT_CNT);
    end else begin
      if (push) begin
        slot_q[wr_q] <= push_tid;
        wr_q         <= step(wr_q);
      end
      if (pop) rd_q <= step(rd_q);
      if (push && !pop)      cnt_q <= cnt_q + 1'b1;
      else if (pop && !push) cnt_q <= cnt_q - 1'b1;
    end
  end

endmodule

// File: rtl/bts_ctx_table.sv
module bts_ctx_table
  import bts_pkg::*;
#(
  parameter int          N_THREADS   = 8,
  parameter int          TID_W       = 3,
  parameter int          PC_W        = 32,
  parameter int unsigned BOOT_BASE   = 32'h0000_1000,
  parameter int unsigned BOOT_STRIDE = 32'h0000_0100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue_en,
  input  logic [TID_W-1:0] issue_tid,
  input  logic             done_valid,
  input  logic [TID_W-1:0] done_tid,
  input  logic [PC_W-1:0]  done_pc,
  input  logic             done_park,
  input  logic [TID_W-1:0] rd_tid,
  output logic [PC_W-1:0]  rd_pc,
  output logic             requeue
);

  th_state_e [N_THREADS-1:0] st_q;
  logic [N_THREADS-1:0][PC_W-1:0] pc_q;
  logic [N_THREADS-1:0] hit;

  // A resolve only counts for a thread that is out of the pool
  for (genvar g = 0; g < N_THREADS; g++) begin : g_hit
    assign hit[g] = done_valid && (done_tid == TID_W'(g)) && (st_q[g] != TH_QUEUED);
  end

  assign requeue = (|hit) && !done_park;
  assign rd_pc   = pc_q[rd_tid];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_THREADS; i++) begin
        st_q[i] <= TH_QUEUED;
        pc_q[i] <= PC_W'(BOOT_BASE + BOOT_STRIDE * i);
      end
    end else begin
      for (int i = 0; i < N_THREADS; i++) begin
        if (issue_en && (issue_tid == TID_W'(i))) begin
          st_q[i] <= TH_INFLIGHT;
        end else if (hit[i]) begin
          st_q[i] <= done_park ? TH_PARKED : TH_QUEUED;
          pc_q[i] <= done_pc;
        end
      end
    end
  end

endmodule

// File: rtl/bts_barrel_fetch.sv
module bts_barrel_fetch #(
  parameter int          N_THREADS   = 8,
  parameter int          PC_W        = 32,
  parameter logic [N_THREADS-1:0] THREAD_EN = '1,
  parameter int unsigned BOOT_BASE   = 32'h0000_1000,
  parameter int unsigned BOOT_STRIDE = 32'h0000_0100,
  localparam int         TID_W       = (N_THREADS > 1) ? $clog2(N_THREADS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic             fetch_valid,
  input  logic             fetch_ready,
  output logic [TID_W-1:0] fetch_tid,
  output logic [PC_W-1:0]  fetch_pc,
  input  logic             done_valid,
  input  logic [TID_W-1:0] done_tid,
  input  logic [PC_W-1:0]  done_pc,
  input  logic             done_park
);

  logic fire;
  logic requeue;

  assign fire = fetch_valid && fetch_ready;

  bts_tid_fifo #(
    .N_THREADS(N_THREADS),
    .TID_W    (TID_W),
    .INIT_MASK(THREAD_EN)
  ) u_pool (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (requeue),
    .push_tid (done_tid),
    .pop      (fire),
    .not_empty(fetch_valid),
    .head_tid (fetch_tid)
  );

  bts_ctx_table #(
    .N_THREADS  (N_THREADS),
    .TID_W      (TID_W),
    .PC_W       (PC_W),
    .BOOT_BASE  (BOOT_BASE),
    .BOOT_STRIDE(BOOT_STRIDE)
  ) u_ctx (
    .clk       (clk),
    .rst_n     (rst_n),
    .issue_en  (fire),
    .issue_tid (fetch_tid),
    .done_valid(done_valid),
    .done_tid  (done_tid),
    .done_pc   (done_pc),
    .done_park (done_park),
    .rd_tid    (fetch_tid),
    .rd_pc     (fetch_pc),
    .requeue   (requeue)
  );

endmodule

// File: rtl/bts_barrel_fetch_chk.sv
module bts_barrel_fetch_chk #(
  parameter int N_THREADS = 8,
  parameter int PC_W      = 32,
  parameter int TID_W     = 3,
  parameter logic [N_THREADS-1:0] THREAD_EN = '1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fetch_valid,
  input logic             fetch_ready,
  input logic [TID_W-1:0] fetch_tid,
  input logic [PC_W-1:0]  fetch_pc,
  input logic             done_valid,
  input logic [TID_W-1:0] done_tid,
  input logic [PC_W-1:0]  done_pc,
  input logic             done_park
);

  logic fire;
  logic [N_THREADS-1:0] out_q, park_q;

  assign fire = fetch_valid && fetch_ready;

  // Port-level view of which threads are out of the pool
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q  <= '0;
      park_q <= '0;
    end else begin
      for (int i = 0; i < N_THREADS; i++) begin
        if (fire && fetch_tid == TID_W'(i)) begin
          out_q[i] <= 1'b1;
        end else if (done_valid && done_tid == TID_W'(i) && (out_q[i] || park_q[i])) begin
          out_q[i]  <= 1'b0;
          park_q[i] <= done_park;
        end
      end
    end
  end

  a_r1_enabled_only: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid |-> THREAD_EN[fetch_tid]);

  a_r2_single_flight: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> !out_q[fetch_tid]);

  a_r3_alternate: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (fire -> (fetch_tid != $past(fetch_tid))));

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && !fetch_ready) |=>
      (fetch_valid && fetch_tid == $past(fetch_tid) && fetch_pc == $past(fetch_pc)));

  a_r8_parked_held: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> !park_q[fetch_tid]);

endmodule

bind bts_barrel_fetch bts_barrel_fetch_chk #(
  .N_THREADS(N_THREADS),
  .PC_W     (PC_W),
  .TID_W    (TID_W),
  .THREAD_EN(THREAD_EN)
) u_chk (.*);

// File: tb/tb_bts_barrel_fetch.sv
module tb_bts_barrel_fetch;

  localparam int N = 8;
  localparam int TW = 3;
  localparam int PW = 32;

  logic clk = 1'b0;
  logic rst_n;
  logic fetch_valid, fetch_ready;
  logic [TW-1:0] fetch_tid;
  logic [PW-1:0] fetch_pc;
  logic done_valid, done_park;
  logic [TW-1:0] done_tid;
  logic [PW-1:0] done_pc;

  int n_tests = 0;
  int n_fail  = 0;
  int order [6] = '{0, 2, 3, 4, 5, 7};

  always #10 clk = ~clk;

  bts_barrel_fetch #(.N_THREADS(N), .PC_W(PW), .THREAD_EN(8'hBD)) dut (
    .clk(clk), .rst_n(rst_n),
    .fetch_valid(fetch_valid), .fetch_ready(fetch_ready),
    .fetch_tid(fetch_tid), .fetch_pc(fetch_pc),
    .done_valid(done_valid), .done_tid(done_tid),
    .done_pc(done_pc), .done_park(done_park)
  );

  task automatic check_eq(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic expect_fetch(string req, logic v, int tid, logic [31:0] pc);
    check_eq(req, "fetch_valid", 32'(fetch_valid), 32'(v));
    if (v) begin
      check_eq(req, "fetch_tid", 32'(fetch_tid), 32'(tid));
      check_eq(req, "fetch_pc", fetch_pc, pc);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic resolve(logic v, int tid, logic [31:0] pc, logic park);
    done_valid = v;
    done_tid   = TW'(tid);
    done_pc    = pc;
    done_park  = park;
  endtask

  // R1, R2, R6: boot order, then no reissue without a resolve
  task automatic t_boot();
    fetch_ready = 1'b1;
    foreach (order[i]) begin
      expect_fetch("R1", 1'b1, order[i], 32'h1000 + 32'(order[i]) * 32'h100);
      tick();
    end
    for (int c = 0; c < 3; c++) begin
      expect_fetch("R2", 1'b0, 0, 0);
      expect_fetch("R6", 1'b0, 0, 0);
      tick();
    end
  endtask

  // R4, R3: resolve returns a thread with its new PC at the tail
  task automatic t_return();
    fetch_ready = 1'b1;
    resolve(1'b1, 4, 32'h2004, 1'b0);
    expect_fetch("R6", 1'b0, 0, 0);
    tick();
    resolve(1'b1, 2, 32'h2002, 1'b0);
    expect_fetch("R4", 1'b1, 4, 32'h2004);
    tick();
    resolve(1'b0, 0, 0, 1'b0);
    expect_fetch("R3", 1'b1, 2, 32'h2002);
    tick();
    expect_fetch("R6", 1'b0, 0, 0);
    fetch_ready = 1'b0;
    resolve(1'b1, 7, 32'h2007, 1'b0);
    tick();
    resolve(1'b1, 0, 32'h2000, 1'b0);
    tick();
    resolve(1'b0, 0, 0, 1'b0);
    expect_fetch("R4", 1'b1, 7, 32'h2007);
  endtask

  // R7, R9: stalled head holds; a resolve for a queued thread is ignored
  task automatic t_hold();
    fetch_ready = 1'b0;
    for (int c = 0; c < 3; c++) begin
      resolve(c == 1, 7, 32'hDEAD, 1'b0);
      expect_fetch("R7", 1'b1, 7, 32'h2007);
      tick();
    end
    resolve(1'b0, 0, 0, 1'b0);
    fetch_ready = 1'b1;
    expect_fetch("R9", 1'b1, 7, 32'h2007);
    tick();
    expect_fetch("R4", 1'b1, 0, 32'h2000);
    tick();
    expect_fetch("R9", 1'b0, 0, 0);
  endtask

  // R8: parked thread stays out until released, keeps the latest PC
  task automatic t_park();
    fetch_ready = 1'b1;
    resolve(1'b1, 3, 32'h3333, 1'b1);
    tick();
    expect_fetch("R8", 1'b0, 0, 0);
    resolve(1'b1, 3, 32'h3334, 1'b1);
    tick();
    expect_fetch("R8", 1'b0, 0, 0);
    resolve(1'b1, 3, 32'h3500, 1'b0);
    tick();
    resolve(1'b0, 0, 0, 1'b0);
    expect_fetch("R8", 1'b1, 3, 32'h3500);
    tick();
    expect_fetch("R6", 1'b0, 0, 0);
  endtask

  // R5: steady rotation with a push and a pop every cycle
  task automatic t_rotate();
    fetch_ready = 1'b0;
    foreach (order[i]) begin
      resolve(1'b1, order[i], 32'h4000 + 32'(order[i]), 1'b0);
      tick();
    end
    resolve(1'b0, 0, 0, 1'b0);
    fetch_ready = 1'b1;
    for (int k = 0; k < 24; k++) begin
      int tid;
      logic [31:0] pc;
      tid = order[k % 6];
      pc  = (k < 6) ? 32'h4000 + 32'(tid) : 32'h8000 + 32'(k - 5) * 4;
      if (k > 0) resolve(1'b1, order[(k - 1) % 6], 32'h8000 + 32'(k) * 4, 1'b0);
      expect_fetch("R5", 1'b1, tid, pc);
      tick();
    end
    resolve(1'b0, 0, 0, 1'b0);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    fetch_ready = 1'b0;
    resolve(1'b0, 0, 0, 1'b0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    expect_fetch("R1", 1'b1, 0, 32'h1000);
    t_boot();
    t_return();
    t_hold();
    t_park();
    t_rotate();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule